// File: doc/BRIEF.md
# Log Page Remap CAM

This block keeps the page remap table for a single flash log block. A data page that has been modified is never rewritten where it sits. Its new contents go to the next unused page of the log block, and the table records which log page now holds which page index. Writes claim log pages strictly in rising order, because flash pages must be programmed in sequence. A single free-page counter therefore does all the allocation work.

A read searches the table by page index across all entries in parallel. If an entry matches, the block returns the row of that log page. If nothing matches, the block returns the row built directly from the requested data-block number and page index. Every search has two phases. In the first phase all match lines are forced to "no select". In the second phase the compare result releases only the matching line.

Requests arrive one at a time over a valid/ready handshake. Each request completes with a one-cycle done pulse, and the row select and hit flag are valid during that pulse.

Top module: `log_remap_cam`

## Requirements
- R1: After reset, reqReady is 1, done, hit and full are 0, rowSel is 0, the free-page counter is 0 and every entry is invalid, so every read misses.
- R2: A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady then stays 0 for two cycles, and no other request is taken until it returns to 1.
- R3: done is 1 for exactly one cycle, the cycle that follows the second rising edge after acceptance. hit and rowSel are valid only while done is 1 and are 0 at all other times.
- R4: While the table is not full, each write takes log page 0, 1, 2 and so on in rising order. It reports hit=1 and rowSel = {LOG_BLOCK, allocated page}, with LOG_BLOCK in the upper BLK_W bits and the page number in the lower PAGE_W bits.
- R5: A read whose page index is held by a valid entry reports hit=1 and rowSel = {LOG_BLOCK, the log page of that entry}.
- R6: A read whose page index is held by no valid entry reports hit=0 and rowSel = {reqBlock, reqPage}, with the block number in the upper bits.
- R7: When a page index is written again, the older entry is invalidated, so later reads return the newest log page. At most one match line is ever active.
- R8: Once all 2^PAGE_W log pages are used, full is 1 and stays 1 until reset. A write while full is refused: it reports hit=0 and rowSel = {reqBlock, reqPage} and leaves the table unchanged.
- R9: A read does not change the table or the free-page counter.
- R10: The search compares only the page index, so a read with any block number finds a page index that was written under another block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; clears the whole table |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block can take a request |
| reqWrite | input | 1 | 1 = write (allocate), 0 = read (search) |
| reqBlock | input | BLK_W | Data-block number of the request |
| reqPage | input | PAGE_W | Page index of the request |
| rowSel | output | BLK_W+PAGE_W | Selected row, valid with done |
| hit | output | 1 | Read: match found; write: mapping recorded |
| full | output | 1 | Every log page has been used |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result is due at a fixed cycle after the request. done, hit and rowSel appear in the cycle after the second rising edge that follows acceptance. A write's effect on the table and on full appears after the third edge. The bench drives inputs on falling edges and samples at the falling edge of each of these cycles. It expects reqReady and done low in the phase-one cycle, reads hit and rowSel in the done cycle, and then expects full updated and the outputs back at zero. Expected rows come from a small model in the bench that tracks the page index mapped to each log page and the free-page count. It covers a sweep of every page index under two block numbers.

// File: rtl/lprc_pkg.sv
package lprc_pkg;
  // strobes from the sequencer to the table datapath
  typedef struct packed {
    logic precharge; // capture request, force all match lines to no-select
    logic evaluate;  // apply the compare, release matching line
    logic commit;    // result cycle; write updates table at its end
  } camStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_EVAL = 2'd2
  } camState_t;
endpackage

// File: rtl/lprc_ctrl.sv
module lprc_ctrl
  import lprc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       done,
  output camStrobe_t strobe
);
  camState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_PRE;
      ST_PRE:  stateNext = ST_EVAL;
      ST_EVAL: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady         = (state == ST_IDLE);
  assign done             = (state == ST_EVAL);
  assign strobe.precharge = (state == ST_IDLE) && reqValid;
  assign strobe.evaluate  = (state == ST_PRE);
  assign strobe.commit    = (state == ST_EVAL);
endmodule

// File: rtl/lprc_datapath.sv
module lprc_datapath
  import lprc_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int PAGE_W = 3,
  parameter logic [BLK_W-1:0] LOG_BLOCK = '1,
  localparam int NUM = 1 << PAGE_W,
  localparam int ROW_W = BLK_W + PAGE_W,
  localparam int PTR_W = PAGE_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  camStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [PAGE_W-1:0] reqPage,
  output logic [ROW_W-1:0]  rowSel,
  output logic              hit,
  output logic              full,
  output logic [NUM-1:0]    matchLine,
  output logic [PTR_W-1:0]  freePtr
);
  logic              latWrite;
  logic [BLK_W-1:0]  latBlock;
  logic [PAGE_W-1:0] latPage;
  logic [NUM-1:0]    cmpHit;
  logic [NUM-1:0]    entryValid;
  logic [PAGE_W-1:0] hitIdx;
  logic              doWrite;

  assign full    = (freePtr == PTR_W'(NUM));
  assign doWrite = strobe.commit && latWrite && !full;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latWrite <= 1'b0;
      latBlock <= '0;
      latPage  <= '0;
    end else if (strobe.precharge) begin
      latWrite <= reqWrite;
      latBlock <= reqBlock;
      latPage  <= reqPage;
    end
  end

  // one entry per physical log page
  for (genvar g = 0; g < NUM; g++) begin : gEntry
    logic              vld;
    logic [PAGE_W-1:0] tag;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld <= 1'b0;
        tag <= '0;
      end else if (doWrite) begin
        if (freePtr[PAGE_W-1:0] == PAGE_W'(g)) begin
          vld <= 1'b1;
          tag <= latPage;
        end else if (matchLine[g]) begin
          vld <= 1'b0; // superseded by the newer mapping
        end
      end
    end
    assign entryValid[g] = vld;
    assign cmpHit[g]     = vld && (tag == latPage);
  end

  // two-phase match lines
  always_ff @(posedge clk) begin
    if (!rstN)                 matchLine <= '0;
    else if (strobe.precharge) matchLine <= '0;
    else if (strobe.evaluate)  matchLine <= cmpHit;
  end

  // in-order free-page pointer
  always_ff @(posedge clk) begin
    if (!rstN)        freePtr <= '0;
    else if (doWrite) freePtr <= freePtr + PTR_W'(1);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM; i++)
      if (matchLine[i]) hitIdx = PAGE_W'(i);
  end

  always_comb begin
    rowSel = '0;
    hit    = 1'b0;
    if (strobe.commit) begin
      if (latWrite) begin
        hit    = !full;
        rowSel = full ? {latBlock, latPage} : {LOG_BLOCK, freePtr[PAGE_W-1:0]};
      end else begin
        hit    = |matchLine;
        rowSel = (|matchLine) ? {LOG_BLOCK, hitIdx} : {latBlock, latPage};
      end
    end
  end

  logic unusedValid;
  assign unusedValid = ^entryValid;
endmodule

// File: rtl/log_remap_cam.sv
module log_remap_cam
  import lprc_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int PAGE_W = 3,
  parameter logic [BLK_W-1:0] LOG_BLOCK = '1,
  localparam int NUM = 1 << PAGE_W,
  localparam int ROW_W = BLK_W + PAGE_W,
  localparam int PTR_W = PAGE_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [PAGE_W-1:0] reqPage,
  output logic [ROW_W-1:0]  rowSel,
  output logic              hit,
  output logic              full,
  output logic              done
);
  camStrobe_t       strobe;
  logic [NUM-1:0]   matchLineW;
  logic [PTR_W-1:0] freePtrW;

  lprc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .done(done), .strobe(strobe)
  );

  lprc_datapath #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .LOG_BLOCK(LOG_BLOCK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqBlock(reqBlock), .reqPage(reqPage),
    .rowSel(rowSel), .hit(hit), .full(full),
    .matchLine(matchLineW), .freePtr(freePtrW)
  );
endmodule

// File: rtl/log_remap_cam_chk.sv
module log_remap_cam_chk #(
  parameter int BLK_W = 4,
  parameter int PAGE_W = 3,
  localparam int NUM = 1 << PAGE_W,
  localparam int ROW_W = BLK_W + PAGE_W,
  localparam int PTR_W = PAGE_W + 1
)(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             done,
  input logic             hit,
  input logic [ROW_W-1:0] rowSel,
  input logic             full,
  input logic [NUM-1:0]   matchLine,
  input logic [PTR_W-1:0] freePtr
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  done_on_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 done);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!hit && rowSel == '0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freePtr != $past(freePtr)) |-> (freePtr == PTR_W'($past(freePtr) + 1'b1)));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchLine));

  // R8
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |=> full);
endmodule

bind log_remap_cam log_remap_cam_chk #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .done(done), .hit(hit), .rowSel(rowSel), .full(full),
  .matchLine(matchLineW), .freePtr(freePtrW)
);

// File: tb/log_remap_cam_tb.sv
`timescale 1ns/1ps
module log_remap_cam_tb;
  localparam int BW = 4;
  localparam int PW = 3;
  localparam int NP = 1 << PW;
  localparam logic [BW-1:0] LB = 4'hF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [BW-1:0] reqBlock = '0;
  logic [PW-1:0] reqPage = '0;
  logic reqReady, hit, full, done;
  logic [BW+PW-1:0] rowSel;

  int total = 0, bad = 0;
  bit finished = 0;
  int mapOf [NP];   // page index -> log page, -1 when none
  int ptr;

  always #4 clk = ~clk;

  log_remap_cam #(.BLK_W(BW), .PAGE_W(PW), .LOG_BLOCK(LB)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBlock(reqBlock), .reqPage(reqPage),
    .rowSel(rowSel), .hit(hit), .full(full), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < NP; i++) mapOf[i] = -1;
    ptr = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(done == 1'b0 && hit == 1'b0, "R1 done/hit", {done, hit}, 0);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(rowSel == '0, "R1 rowSel", rowSel, 0);
    rstN = 1'b1;
    modelClear();
  endtask

  // issues at a falling edge; returns at the falling edge after completion
  task automatic doReq(input logic wr, input int blk, input int pg, input string tag,
                       output logic [BW+PW-1:0] rs, output logic h);
    reqValid = 1'b1; reqWrite = wr; reqBlock = BW'(blk); reqPage = PW'(pg);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    // R2 busy in phase one, R3 no result yet
    chk(reqReady == 1'b0, {tag, " R2 busy"}, reqReady, 0);
    chk(done == 1'b0, {tag, " R3 early done"}, done, 0);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, {tag, " R3 done"}, done, 1);
    chk(reqReady == 1'b0, {tag, " R2 busy2"}, reqReady, 0);
    rs = rowSel; h = hit;
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0 && reqReady == 1'b1, {tag, " R3 end"}, {done, reqReady}, 1);
    chk(hit == 1'b0 && rowSel == '0, {tag, " R3 quiet"}, rowSel, 0);
  endtask

  task automatic rd(input int blk, input int pg, input string tag);
    logic [BW+PW-1:0] rs; logic h; logic [BW+PW-1:0] er; logic eh;
    doReq(1'b0, blk, pg, tag, rs, h);
    if (mapOf[pg] >= 0) begin eh = 1'b1; er = {LB, PW'(mapOf[pg])}; end
    else begin eh = 1'b0; er = {BW'(blk), PW'(pg)}; end
    chk(h == eh, {tag, " hit"}, h, eh);
    chk(rs == er, {tag, " row"}, rs, er);
  endtask

  task automatic sweep(input int blk, input string tag);
    for (int p = 0; p < NP; p++) rd(blk + p, p, tag);
  endtask

  task automatic wr(input int blk, input int pg, input string tag);
    logic [BW+PW-1:0] rs; logic h; logic [BW+PW-1:0] er; logic eh;
    doReq(1'b1, blk, pg, tag, rs, h);
    if (ptr < NP) begin
      eh = 1'b1; er = {LB, PW'(ptr)};
      for (int i = 0; i < NP; i++) if (mapOf[i] == ptr) mapOf[i] = -1;
      mapOf[pg] = ptr; ptr++;
    end else begin
      eh = 1'b0; er = {BW'(blk), PW'(pg)};
    end
    chk(h == eh, {tag, " hit"}, h, eh);
    chk(rs == er, {tag, " row"}, rs, er);
    // R8 full reflects the count after commit
    chk(full == (ptr == NP), {tag, " R8 full"}, full, ptr == NP);
  endtask

  initial begin
    modelClear();
    doReset();
    sweep(2, "R1 R6 empty");
    for (int i = 0; i < 5; i++) wr(i, (3 * i + 1) % NP, "R4 alloc");
    sweep(0, "R5 R6 R10 blkA");
    sweep(7, "R5 R6 R10 blkB");
    sweep(7, "R9 repeat");
    wr(9, 4, "R7 rewrite1");
    rd(1, 4, "R7 newest1");
    wr(10, 4, "R7 rewrite2");
    rd(3, 4, "R7 newest2");
    sweep(5, "R7 R5 after rewrite");
    wr(11, 0, "R4 R8 last");
    wr(12, 3, "R8 refused");
    wr(13, 6, "R8 refused2");
    rd(12, 3, "R8 unchanged");
    sweep(1, "R8 R9 full table");
    doReset();
    sweep(4, "R1 after reset");
    wr(2, 6, "R4 restart");
    rd(8, 6, "R5 restart");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule